// File: doc/BRIEF.md
# Transmit Frame Descriptor Queue

This block sits between a host that prepares outgoing frames in a shared memory window and the byte-wide transmit path of a network port. The host builds a frame descriptor in memory: a 16-byte little-endian header followed by up to 2024 payload bytes. It then writes a command word naming the descriptor's byte offset into a command register. Commands wait in a FIFO and are serviced strictly in the order they arrived.

For each command the block reads the two header words it needs through a simple one-cycle-latency memory read port. It then fetches the payload one 32-bit word at a time and sends it out as bytes on a valid/ready stream. A two-bit port select, taken from the header, travels with the bytes. Once the final byte has been accepted, the block writes the header's status word back with bit 0 set, so the host can see that the slot may be reused. A small register space lets the host push commands, flush the queue, read and clear a transmitted-frame counter, and read the queue fill level together with a sticky overflow flag.

Top module: `txdesc_queue`

## Requirements
- R1: After a synchronous reset the queue is empty, the fill level, overflow flag and frame counter all read zero, `tx_valid` is low and no memory write is issued.
- R2: A register write at address 0x00 queues a command. Bits [23:2] of the written word give the descriptor's 32-bit word address, and bits [31:24] (the rounded total length) and bits [1:0] are ignored.
- R3: A command write while the queue holds FIFO_DEPTH entries is dropped and sets a sticky overflow flag. The flag reads as bit 16 of address 0x20 and is cleared only by a flush.
- R4: Any register write at address 0x08 empties the queue and clears the overflow flag. A frame whose command was already taken still completes.
- R5: Header word 0 is read little-endian: payload length in bits [15:0] and port mask in bits [23:16]. Mask bits 0 and 1 appear on `tx_port[0]` (port 0) and `tx_port[1]` (port 1), and higher mask bits have no effect.
- R6: Payload bytes are read from descriptor byte offset 16 onward, lowest byte lane first within each word. The count is the header length, limited to LEN_MAX (default 2024) when the header length is larger.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_port` hold steady. `tx_last` is high on the final byte only.
- R8: After the final byte is accepted, the block writes header word 1 (the status word) with bit 0 set and all other bits as read. No write-back occurs while a byte of the frame is still pending.
- R9: A descriptor with a payload length of zero sends no bytes but still receives the status write-back.
- R10: Queued commands are serviced one at a time, in the order they were written.
- R11: The frame counter at address 0x10 rises by one per status write-back. A register write of zero to 0x10 clears it, and a non-zero write to 0x10 leaves it unchanged.
- R12: A read returns data on `reg_rd_data` one cycle after `reg_rd_en`. Address 0x20 gives the fill level in bits [15:0], address 0x10 gives the counter, and any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 8 | Register read byte address |
| reg_rd_data | output | 32 | Register read data, one cycle after the strobe |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 22 | Memory word address for reads |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe (status write-back) |
| mem_wr_addr | output | 22 | Memory word address for the write |
| mem_wr_data | output | 32 | Status word with bit 0 set |
| tx_valid | output | 1 | Payload byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Payload byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_port | output | 2 | Port select from the header mask |

## Verification
Frames are sent with lengths of 1, 4, 7 and 64 bytes. These show whether byte lanes are picked in the right order and whether the stream ends on a partial or a whole word. A zero length checks that the write-back happens without any bytes, and an oversize length checks the clamp. The sink accepts bytes always, every other cycle, or one cycle in three, which shows whether data holds steady under back-pressure. Distinct per-slot byte patterns, non-zero status words and junk in the command's upper byte show that the right descriptor was fetched, that status bits were preserved, and that the queue runs in order across overflow and flush.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  localparam int OFF_W      = 24;          // byte offset field of a command
  localparam int MEM_AW     = OFF_W - 2;   // 32-bit word address
  localparam int HDR_WORDS  = 4;           // 16-byte header
  localparam int STAT_WORD  = 1;           // status word index in header
  localparam logic [7:0] A_CMD    = 8'h00;
  localparam logic [7:0] A_FLUSH  = 8'h08;
  localparam logic [7:0] A_FRAMES = 8'h10;
  localparam logic [7:0] A_LEVEL  = 8'h20;

  typedef enum logic [2:0] {
    S_IDLE, S_H0, S_H1, S_H2, S_PW, S_PD, S_SEND, S_WB
  } eng_state_t;
endpackage

// File: rtl/txdesc_cmd_fifo.sv
module txdesc_cmd_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 22,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [W-1:0]  head,
  output logic          not_empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full      = (level == CW'(DEPTH));
  assign not_empty = (level != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign head      = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      level <= level + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> level == $past(level)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> level == '0); // R4
endmodule

// File: rtl/txdesc_csr.sv
module txdesc_csr import txdesc_pkg::*; #(
  parameter int LVL_W = 7,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [7:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic             q_full,
  input  logic [LVL_W-1:0] q_level,
  input  logic             frame_done,
  output logic             push,
  output logic             flush
);
  logic             ovf;
  logic [CNT_W-1:0] frames;
  logic             clr;

  assign push  = wr_en && (wr_addr == A_CMD);
  assign flush = wr_en && (wr_addr == A_FLUSH);
  assign clr   = wr_en && (wr_addr == A_FRAMES) && (wr_data == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0; frames <= '0; rd_data <= '0;
    end else begin
      if (flush)              ovf <= 1'b0;
      else if (push && q_full) ovf <= 1'b1;
      if (clr)             frames <= '0;
      else if (frame_done) frames <= frames + 1'b1;
      if (rd_en) begin
        case (rd_addr)
          A_FRAMES: rd_data <= 32'(frames);
          A_LEVEL:  rd_data <= {15'd0, ovf, 16'(q_level)};
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !flush) |=> ovf); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && !frame_done) |=> frames == $past(frames)); // R11
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine import txdesc_pkg::*; #(
  parameter int LEN_MAX = 2024,
  localparam int LEN_W  = $clog2(LEN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [MEM_AW-1:0] cmd_base,
  output logic              cmd_pop,
  output logic              mem_rd_req,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_en,
  output logic [MEM_AW-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [1:0]        tx_port
);
  eng_state_t        st;
  logic [MEM_AW-1:0] base;
  logic [LEN_W-1:0]  rem;
  logic [31:0]       status, word;
  logic [1:0]        lane;
  logic              take;

  assign cmd_pop = (st == S_IDLE) && cmd_valid;
  assign tx_data = word[8*lane +: 8];
  assign tx_last = (rem == LEN_W'(1));
  assign take    = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; base <= '0; rem <= '0; status <= '0; word <= '0;
      lane <= '0; tx_valid <= 1'b0; tx_port <= '0;
      mem_rd_req <= 1'b0; mem_rd_addr <= '0;
      mem_wr_en <= 1'b0; mem_wr_addr <= '0; mem_wr_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          base <= cmd_base; mem_rd_req <= 1'b1; mem_rd_addr <= cmd_base;
          st <= S_H0;
        end
        S_H0: begin
          mem_rd_addr <= base + MEM_AW'(STAT_WORD);
          st <= S_H1;
        end
        S_H1: begin
          rem <= (mem_rd_data[15:0] > 16'(LEN_MAX)) ? LEN_W'(LEN_MAX)
                                                     : mem_rd_data[LEN_W-1:0];
          tx_port <= mem_rd_data[17:16];
          mem_rd_req <= 1'b0;
          st <= S_H2;
        end
        S_H2: begin
          status <= mem_rd_data;
          if (rem == '0) begin
            mem_wr_en <= 1'b1; mem_wr_addr <= base + MEM_AW'(STAT_WORD);
            mem_wr_data <= mem_rd_data | 32'd1;
            st <= S_WB;
          end else begin
            mem_rd_req <= 1'b1; mem_rd_addr <= base + MEM_AW'(HDR_WORDS);
            st <= S_PW;
          end
        end
        S_PW: begin
          mem_rd_req <= 1'b0;
          st <= S_PD;
        end
        S_PD: begin
          word <= mem_rd_data; lane <= '0; tx_valid <= 1'b1;
          st <= S_SEND;
        end
        S_SEND: if (take) begin
          if (rem == LEN_W'(1)) begin
            tx_valid <= 1'b0; rem <= '0;
            mem_wr_en <= 1'b1; mem_wr_addr <= base + MEM_AW'(STAT_WORD);
            mem_wr_data <= status | 32'd1;
            st <= S_WB;
          end else begin
            rem <= rem - 1'b1;
            if (lane == 2'd3) begin
              tx_valid <= 1'b0; mem_rd_req <= 1'b1;
              mem_rd_addr <= mem_rd_addr + 1'b1;
              st <= S_PW;
            end else begin
              lane <= lane + 1'b1;
            end
          end
        end
        S_WB: begin
          mem_wr_en <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data)
      && $stable(tx_last) && $stable(tx_port)); // R7
  AST_WB_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (take && tx_last) |=> mem_wr_en); // R8
  AST_NO_WB_MID_FRAME: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !tx_valid); // R8
  AST_WB_BIT0: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> mem_wr_data[0]); // R8
  AST_ONE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (cmd_pop && cmd_valid) |=> !cmd_pop); // R10
endmodule

// File: rtl/txdesc_queue.sv
module txdesc_queue import txdesc_pkg::*; #(
  parameter int FIFO_DEPTH = 64,
  parameter int LEN_MAX    = 2024,
  parameter int CNT_W      = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic              reg_rd_en,
  input  logic [7:0]        reg_rd_addr,
  output logic [31:0]       reg_rd_data,
  output logic              mem_rd_req,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_en,
  output logic [MEM_AW-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [1:0]        tx_port
);
  logic              push, flush, pop, q_ne, q_full;
  logic [MEM_AW-1:0] q_head;
  logic [LVL_W-1:0]  q_level;

  txdesc_csr #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_csr (
    .clk, .rst,
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .q_full, .q_level, .frame_done(mem_wr_en), .push, .flush
  );

  txdesc_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(MEM_AW)) u_fifo (
    .clk, .rst, .push, .push_data(reg_wr_data[OFF_W-1:2]), .pop, .flush,
    .head(q_head), .not_empty(q_ne), .full(q_full), .level(q_level)
  );

  txdesc_engine #(.LEN_MAX(LEN_MAX)) u_eng (
    .clk, .rst, .cmd_valid(q_ne), .cmd_base(q_head), .cmd_pop(pop),
    .mem_rd_req, .mem_rd_addr, .mem_rd_data,
    .mem_wr_en, .mem_wr_addr, .mem_wr_data,
    .tx_valid, .tx_ready, .tx_data, .tx_last, .tx_port
  );
endmodule

// File: tb/txdesc_queue_bench.sv
module txdesc_queue_bench;
  import txdesc_pkg::*;
  localparam int DEPTH   = 64;
  localparam int LEN_MAX = 2024;
  localparam int SLOTW   = 510;          // 2040-byte slot in words
  localparam int NV      = 6;
  localparam int V_SLOT [NV] = '{0, 1, 2, 3, 4, 5};
  localparam int V_LEN  [NV] = '{1, 4, 7, 64, 0, 3000};
  localparam int V_PORT [NV] = '{1, 2, 'h07, 1, 2, 1};
  localparam int V_STAT [NV] = '{0, 'h100, 'hA0, 0, 'h5A0, 'h2};
  localparam int V_MODE [NV] = '{0, 1, 2, 0, 0, 1};

  logic clk = 0, rst = 1;
  logic reg_wr_en = 0, reg_rd_en = 0, tx_ready = 0;
  logic [7:0] reg_wr_addr = 0, reg_rd_addr = 0;
  logic [31:0] reg_wr_data = 0, reg_rd_data, mem_rd_data = 0, mem_wr_data;
  logic mem_rd_req, mem_wr_en, tx_valid, tx_last;
  logic [MEM_AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] tx_data;
  logic [1:0] tx_port;
  logic [31:0] bmem [4096];
  int tests = 0, fails = 0, wb_count = 0, frames_exp = 0;
  logic last_acc = 0, wb_early = 0;

  always #4 clk = ~clk;

  txdesc_queue u_txdesc_queue (.*);

  always @(posedge clk) begin
    if (mem_rd_req) mem_rd_data <= bmem[mem_rd_addr[11:0]];
    if (mem_wr_en) begin
      bmem[mem_wr_addr[11:0]] <= mem_wr_data;
      wb_count <= wb_count + 1;
      wb_early <= !last_acc;
    end
  end

  function automatic logic [7:0] pbyte(int s, int i);
    return 8'(s * 37 + i * 3 + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic init_slot(input int s, input int len, input int port, input int st);
    int b;
    b = s * SLOTW;
    bmem[b]   = {8'h55, 8'(port), 16'(len)};
    bmem[b+1] = 32'(st);
    bmem[b+2] = 0; bmem[b+3] = 0;
    for (int k = 0; k < 506; k++)
      bmem[b+4+k] = {pbyte(s, 4*k+3), pbyte(s, 4*k+2), pbyte(s, 4*k+1), pbyte(s, 4*k)};
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1; reg_rd_addr = a;
    @(negedge clk); reg_rd_en = 0; d = reg_rd_data;
  endtask

  function automatic logic [31:0] cmd_for(int s, int junk);
    return {8'(junk), 24'(s * 2040)};
  endfunction

  task automatic collect(input int s, input int len, input int port,
                         input int st, input int mode);
    int n, got, lastpos, cyc, bad_b, bad_p, bad_s, wbc0;
    logic held; logic [7:0] hd; logic hl;
    n = (len > LEN_MAX) ? LEN_MAX : len;
    got = 0; lastpos = -1; cyc = 0; bad_b = 0; bad_p = 0; bad_s = 0;
    held = 0; hd = 0; hl = 0; wbc0 = wb_count; last_acc = (n == 0);
    while (wb_count == wbc0 && cyc < 20000) begin
      @(negedge clk);
      tx_ready = (mode == 0) || (mode == 1 && cyc % 2 == 0) || (mode == 2 && cyc % 3 == 2);
      #1;
      if (held) begin
        if (!tx_valid || tx_data != hd || tx_last != hl) bad_s++;
        held = 0;
      end
      if (tx_valid) begin
        if (tx_ready) begin
          if (tx_data != pbyte(s, got)) bad_b++;
          if (tx_port != 2'(port)) bad_p++;
          if (tx_last) begin lastpos = got; last_acc = 1; end
          got++;
        end else begin
          held = 1; hd = tx_data; hl = tx_last;
        end
      end
      cyc++;
    end
    tx_ready = 0;
    frames_exp++;
    if (n == 0) check(got == 0, "R9", "bytes sent for zero length", got, 0);
    else        check(got == n, "R6", "payload byte count", got, n);
    check(bad_b == 0, "R6", "payload byte mismatches", bad_b, 0);
    check(bad_p == 0, "R5", "port select mismatches", bad_p, 0);
    check(lastpos == n - 1, "R7", "position of last flag", lastpos, n - 1);
    check(bad_s == 0, "R7", "unstable outputs under stall", bad_s, 0);
    check(wb_count == wbc0 + 1 && !wb_early, "R8", "write-back after last",
          wb_count - wbc0, 1);
    check(bmem[s*SLOTW+1] == (32'(st) | 32'd1), "R8", "status word",
          bmem[s*SLOTW+1], st | 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 4096; i++) bmem[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    #1 check(!tx_valid && !mem_wr_en, "R1", "idle outputs", {tx_valid, mem_wr_en}, 0);
    reg_read(A_LEVEL, rd);  check(rd == 0, "R1", "level after reset", rd, 0);
    reg_read(A_FRAMES, rd); check(rd == 0, "R1", "counter after reset", rd, 0);
    reg_read(8'h04, rd);    check(rd == 0, "R12", "unmapped read", rd, 0);

    // Vector table (R2 junk upper byte and low offset bits)
    for (int v = 0; v < NV; v++) begin
      init_slot(V_SLOT[v], V_LEN[v], V_PORT[v], V_STAT[v]);
      reg_write(A_CMD, cmd_for(V_SLOT[v], 8'hC3 + v) | 32'(v % 2) * 2);
      collect(V_SLOT[v], V_LEN[v], V_PORT[v], V_STAT[v], V_MODE[v]);
    end

    // R3 overflow, R4 flush with a frame in flight
    init_slot(3, 64, 2, 'h30);
    reg_write(A_CMD, cmd_for(3, 0));
    repeat (10) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) reg_write(A_CMD, cmd_for(0, 0));
    reg_read(A_LEVEL, rd); check(rd == DEPTH, "R12", "fill level when full", rd, DEPTH);
    reg_write(A_CMD, cmd_for(1, 0));
    reg_read(A_LEVEL, rd);
    check(rd == (32'h1_0000 | DEPTH), "R3", "overflow flag and level", rd, 32'h1_0000 | DEPTH);
    reg_write(A_FLUSH, 32'h0);
    reg_read(A_LEVEL, rd); check(rd == 0, "R4", "level after flush", rd, 0);
    collect(3, 64, 2, 'h30, 2);
    repeat (20) @(negedge clk);
    check(!tx_valid && !mem_rd_req, "R4", "no frame after flush", {tx_valid, mem_rd_req}, 0);

    // R10 in-order service
    init_slot(6, 5, 1, 'h10);
    init_slot(0, 2, 2, 'h20);
    init_slot(2, 9, 3, 'h40);
    reg_write(A_CMD, cmd_for(6, 8'hFF));
    reg_write(A_CMD, cmd_for(0, 8'h11));
    reg_write(A_CMD, cmd_for(2, 8'h22));
    $display("R10 in-order frames");
    collect(6, 5, 1, 'h10, 0);
    collect(0, 2, 2, 'h20, 1);
    collect(2, 9, 3, 'h40, 0);

    // R11 counter
    reg_read(A_FRAMES, rd); check(rd == frames_exp, "R11", "frame count", rd, frames_exp);
    reg_write(A_FRAMES, 32'd5);
    reg_read(A_FRAMES, rd); check(rd == frames_exp, "R11", "non-zero write ignored", rd, frames_exp);
    reg_write(A_FRAMES, 32'd0);
    reg_read(A_FRAMES, rd); check(rd == 0, "R11", "cleared by zero write", rd, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule